// File: doc/BRIEF.md
# Interrupt and Serial-Bus Glue

This block sits between two timer/port peripherals, a video controller and the processor of an 8-bit home computer. It merges interrupt sources into the processor's maskable request and its non-maskable request. The maskable request is formed from the first peripheral's line and a stored copy of the video controller's line. The non-maskable request is formed from a synchronised restore key and the second peripheral's line. Each request is held in a register that changes only when its merged source level differs from the stored value.

The second peripheral's port A also feeds the block. Its bits 5..3 steer a three-wire open-collector serial bus. Its bits 1..0 choose which 16 KB window the video controller fetches from. The clock and data wires of the bus are sensed back into port A bits 6 and 7 as the wired-AND of the local pull and any external pull. A port pin set as an input by the direction register counts as a 1, as a pulled-up pin would.

Top module: `irq_serial_glue`

## Requirements
- R1: `cpu_irq` goes to the OR of `tmr0_int` and the stored video level on the clock edge after the change, so a change of `tmr0_int` appears one edge later.
- R2: The video interrupt level is stored in a register that is 0 after reset, so a change of `vid_int` reaches `cpu_irq` on the second clock edge.
- R3: `cpu_nmi` follows the OR of `tmr1_int` and the synchronised restore key one clock edge after the merged level changes.
- R4: `restore_key` passes through two synchroniser flip-flops, so a change of it reaches `cpu_nmi` on the third clock edge.
- R5: While the merged source level of a request equals its stored level, the request output holds its value.
- R6: The bus field index 0 (port bit 3) drives ATN, index 1 (port bit 4) drives CLK and index 2 (port bit 5) drives DATA; each `bus_*_low` output is 1 (line pulled low) when its effective port bit is 1.
- R7: A port bit whose direction bit is 0 (input) is treated as 1 for both the bus drive and the bank select.
- R8: `pa_rd` bits 5..0 read 1; bit 6 reads 0 when the CLK line is low through either the local pull or `bus_clk_ext` = 0; bit 7 does the same for the DATA line with `bus_data_ext`.
- R9: `vid_bank` holds address bits 15..14 of the video window, loaded on each clock edge from the effective bank bits: 00 gives 2'b11 (0xC000), 01 gives 2'b10 (0x8000), 10 gives 2'b01 (0x4000), 11 gives 2'b00 (0x0000).
- R10: While `rst_n` is low, `cpu_irq`, `cpu_nmi` and `vid_bank` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr0_int | input | 1 | First peripheral interrupt, active high |
| tmr1_int | input | 1 | Second peripheral interrupt, active high |
| vid_int | input | 1 | Video controller interrupt, active high |
| restore_key | input | 1 | Restore key, active high, asynchronous |
| pa_bus_out | input | 3 | Port A output bits 5..3 (DATA, CLK, ATN) |
| pa_bus_dir | input | 3 | Port A direction bits 5..3, 1 = output |
| pa_bank_out | input | 2 | Port A output bits 1..0 |
| pa_bank_dir | input | 2 | Port A direction bits 1..0, 1 = output |
| bus_clk_ext | input | 1 | External state of CLK wire, 0 = pulled low elsewhere |
| bus_data_ext | input | 1 | External state of DATA wire, 0 = pulled low elsewhere |
| cpu_irq | output | 1 | Maskable interrupt request, active high |
| cpu_nmi | output | 1 | Non-maskable interrupt request, active high |
| bus_atn_low | output | 1 | 1 = pull ATN wire low |
| bus_clk_low | output | 1 | 1 = pull CLK wire low |
| bus_data_low | output | 1 | 1 = pull DATA wire low |
| pa_rd | output | 8 | Value returned on a port A read |
| vid_bank | output | 2 | Video window address bits 15..14 |

## Verification
On every cycle, the assertions check four things. Each request register follows its merged source one edge later and holds while no level change is flagged. The stored video level follows its input. The bank register loads the inverted effective bank bits. The read-back bits agree with the local and external pulls on the clock and data wires. The bench scenarios show three things the cycle properties do not reach. They count the full latencies from the pins, including the three-edge path through the restore synchroniser and the two-edge video path. They check the direction-register override on the bus drives and on the bank select. They check the exact bank-to-window table.

// File: rtl/glue_pkg.sv
package glue_pkg;

  localparam int BUS_LINES  = 3;
  localparam int BANK_W     = 2;
  localparam int RD_W       = 8;
  localparam int LINE_ATN   = 0;
  localparam int LINE_CLK   = 1;
  localparam int LINE_DATA  = 2;
  localparam int SENSE_CLK  = 6;
  localparam int SENSE_DATA = 7;

  // A pin configured as input reads as pulled up.
  function automatic logic eff_bit(input logic out_v, input logic dir_v);
    return out_v | ~dir_v;
  endfunction

  // Window base bits 15..14 from the select field: the mapping is inverted.
  function automatic logic [BANK_W-1:0] window_bits(input logic [BANK_W-1:0] sel);
    return ~sel;
  endfunction

  // Open-collector wire level: high only when nobody pulls it low.
  function automatic logic wire_level(input logic local_low, input logic ext_level);
    return ~local_low & ext_level;
  endfunction

endpackage

// File: rtl/glue_sync.sv
module glue_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[TOP-1:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[TOP];
endmodule

// File: rtl/glue_level_latch.sv
module glue_level_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic level_q,
  output logic change_evt
);
  assign change_evt = (level_in != level_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          level_q <= 1'b0;
    else if (change_evt) level_q <= level_in;
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !change_evt |=> $stable(level_q));
endmodule

// File: rtl/glue_serial_map.sv
module glue_serial_map
  import glue_pkg::*;
(
  input  logic [BUS_LINES-1:0] bus_out,
  input  logic [BUS_LINES-1:0] bus_dir,
  input  logic                 clk_ext,
  input  logic                 data_ext,
  output logic [BUS_LINES-1:0] drv_low,
  output logic [RD_W-1:0]      rd_byte
);
  genvar i;
  generate
    for (i = 0; i < BUS_LINES; i++) begin : g_line
      assign drv_low[i] = eff_bit(bus_out[i], bus_dir[i]);
    end
  endgenerate

  logic clk_line, data_line;
  assign clk_line  = wire_level(drv_low[LINE_CLK],  clk_ext);
  assign data_line = wire_level(drv_low[LINE_DATA], data_ext);

  always_comb begin
    rd_byte             = '1;
    rd_byte[SENSE_CLK]  = clk_line;
    rd_byte[SENSE_DATA] = data_line;
  end

  always_comb begin
    if (!drv_low[LINE_CLK] && clk_ext)
      assert_clk_sense_R8: assert (rd_byte[SENSE_CLK]);
    if (!drv_low[LINE_DATA] && data_ext)
      assert_data_sense_R8: assert (rd_byte[SENSE_DATA]);
    if (!bus_dir[LINE_ATN])
      assert_atn_input_R7: assert (drv_low[LINE_ATN]);
  end
endmodule

// File: rtl/glue_bank_sel.sv
module glue_bank_sel
  import glue_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] sel_out,
  input  logic [BANK_W-1:0] sel_dir,
  output logic [BANK_W-1:0] bank_q
);
  logic [BANK_W-1:0] sel_eff;

  genvar i;
  generate
    for (i = 0; i < BANK_W; i++) begin : g_bit
      assign sel_eff[i] = eff_bit(sel_out[i], sel_dir[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= window_bits(sel_eff);
  end

  assert_bank_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bank_q ^ $past(sel_eff)) == {BANK_W{1'b1}}));
endmodule

// File: rtl/irq_serial_glue.sv
module irq_serial_glue
  import glue_pkg::*;
#(
  parameter int RESTORE_SYNC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tmr0_int,
  input  logic                 tmr1_int,
  input  logic                 vid_int,
  input  logic                 restore_key,
  input  logic [BUS_LINES-1:0] pa_bus_out,
  input  logic [BUS_LINES-1:0] pa_bus_dir,
  input  logic [BANK_W-1:0]    pa_bank_out,
  input  logic [BANK_W-1:0]    pa_bank_dir,
  input  logic                 bus_clk_ext,
  input  logic                 bus_data_ext,
  output logic                 cpu_irq,
  output logic                 cpu_nmi,
  output logic                 bus_atn_low,
  output logic                 bus_clk_low,
  output logic                 bus_data_low,
  output logic [RD_W-1:0]      pa_rd,
  output logic [BANK_W-1:0]    vid_bank
);
  // Stored video interrupt level.
  logic vid_level_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vid_level_q <= 1'b0;
    else        vid_level_q <= vid_int;
  end

  logic restore_sync;
  glue_sync #(.STAGES(RESTORE_SYNC)) u_restore_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (restore_key),
    .q_sync  (restore_sync)
  );

  // Named merged sources and change events for the properties.
  logic irq_src, nmi_src, irq_change, nmi_change;
  assign irq_src = tmr0_int | vid_level_q;
  assign nmi_src = tmr1_int | restore_sync;

  glue_level_latch u_irq_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_in   (irq_src),
    .level_q    (cpu_irq),
    .change_evt (irq_change)
  );

  glue_level_latch u_nmi_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_in   (nmi_src),
    .level_q    (cpu_nmi),
    .change_evt (nmi_change)
  );

  logic [BUS_LINES-1:0] drv_low;
  glue_serial_map u_serial (
    .bus_out  (pa_bus_out),
    .bus_dir  (pa_bus_dir),
    .clk_ext  (bus_clk_ext),
    .data_ext (bus_data_ext),
    .drv_low  (drv_low),
    .rd_byte  (pa_rd)
  );
  assign bus_atn_low  = drv_low[LINE_ATN];
  assign bus_clk_low  = drv_low[LINE_CLK];
  assign bus_data_low = drv_low[LINE_DATA];

  glue_bank_sel u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_out (pa_bank_out),
    .sel_dir (pa_bank_dir),
    .bank_q  (vid_bank)
  );

  assert_irq_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_int |=> cpu_irq);
  assert_irq_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr0_int && !vid_level_q) |=> !cpu_irq);
  assert_vid_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vid_int |=> vid_level_q);
  assert_nmi_timer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr1_int |=> cpu_nmi);
  assert_nmi_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr1_int && !restore_sync) |=> !cpu_nmi);
  assert_irq_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(cpu_irq) |-> $past(irq_change));
  assert_nmi_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(cpu_nmi) |-> $past(nmi_change));

  always_comb begin
    if (!rst_n) begin
      assert_reset_R10: assert (!cpu_irq && !cpu_nmi && vid_bank == '0);
    end
  end
endmodule

// File: tb/irq_serial_glue_test.sv
module irq_serial_glue_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmr0_int = 1'b0, tmr1_int = 1'b0, vid_int = 1'b0, restore_key = 1'b0;
  logic [2:0] pa_bus_out = '0, pa_bus_dir = '0;
  logic [1:0] pa_bank_out = '0, pa_bank_dir = '0;
  logic       bus_clk_ext = 1'b1, bus_data_ext = 1'b1;
  logic       cpu_irq, cpu_nmi, bus_atn_low, bus_clk_low, bus_data_low;
  logic [7:0] pa_rd;
  logic [1:0] vid_bank;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  irq_serial_glue uut (
    .clk(clk), .rst_n(rst_n), .tmr0_int(tmr0_int), .tmr1_int(tmr1_int),
    .vid_int(vid_int), .restore_key(restore_key), .pa_bus_out(pa_bus_out),
    .pa_bus_dir(pa_bus_dir), .pa_bank_out(pa_bank_out), .pa_bank_dir(pa_bank_dir),
    .bus_clk_ext(bus_clk_ext), .bus_data_ext(bus_data_ext), .cpu_irq(cpu_irq),
    .cpu_nmi(cpu_nmi), .bus_atn_low(bus_atn_low), .bus_clk_low(bus_clk_low),
    .bus_data_low(bus_data_low), .pa_rd(pa_rd), .vid_bank(vid_bank)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic logic [1:0] exp_window(input logic [1:0] sel);
    case (sel)
      2'b00:   return 2'b11;
      2'b01:   return 2'b10;
      2'b10:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  task automatic t_reset;
    step(2);
    chk("R10 irq in reset", {7'd0, cpu_irq}, 8'h00);
    chk("R10 nmi in reset", {7'd0, cpu_nmi}, 8'h00);
    chk("R10 bank in reset", {6'd0, vid_bank}, 8'h00);
    pa_bus_dir = 3'b111; pa_bank_dir = 2'b11; pa_bank_out = 2'b11;
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_irq_timer;
    tmr0_int = 1'b1;
    #1 chk("R1 irq before edge", {7'd0, cpu_irq}, 8'h00);
    step(1);
    chk("R1 irq after one edge", {7'd0, cpu_irq}, 8'h01);
    tmr0_int = 1'b0;
    step(1);
    chk("R1 irq drops", {7'd0, cpu_irq}, 8'h00);
  endtask

  task automatic t_irq_video;
    vid_int = 1'b1;
    step(1);
    chk("R2 irq after one edge", {7'd0, cpu_irq}, 8'h00);
    step(1);
    chk("R2 irq after two edges", {7'd0, cpu_irq}, 8'h01);
    vid_int = 1'b0;
    step(1);
    chk("R2 irq held one edge", {7'd0, cpu_irq}, 8'h01);
    step(1);
    chk("R2 irq drops", {7'd0, cpu_irq}, 8'h00);
  endtask

  task automatic t_nmi_timer;
    tmr1_int = 1'b1;
    step(1);
    chk("R3 nmi from timer", {7'd0, cpu_nmi}, 8'h01);
    tmr1_int = 1'b0;
    step(1);
    chk("R3 nmi drops", {7'd0, cpu_nmi}, 8'h00);
  endtask

  task automatic t_nmi_restore;
    restore_key = 1'b1;
    step(2);
    chk("R4 nmi after two edges", {7'd0, cpu_nmi}, 8'h00);
    step(1);
    chk("R4 nmi after three edges", {7'd0, cpu_nmi}, 8'h01);
    restore_key = 1'b0;
    step(2);
    chk("R4 nmi held during sync", {7'd0, cpu_nmi}, 8'h01);
    step(1);
    chk("R4 nmi drops", {7'd0, cpu_nmi}, 8'h00);
  endtask

  task automatic t_hold;
    tmr0_int = 1'b1; vid_int = 1'b1; tmr1_int = 1'b1;
    step(3);
    tmr0_int = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step(1);
      chk("R5 irq held by video", {7'd0, cpu_irq}, 8'h01);
    end
    restore_key = 1'b1;
    step(3);
    tmr1_int = 1'b0;
    step(1);
    chk("R5 nmi held by restore", {7'd0, cpu_nmi}, 8'h01);
    vid_int = 1'b0; restore_key = 1'b0;
    step(4);
    chk("R5 both released", {6'd0, cpu_nmi, cpu_irq}, 8'h00);
  endtask

  task automatic t_drive;
    pa_bus_dir = 3'b111;
    for (int v = 0; v < 8; v++) begin
      pa_bus_out = 3'(v);
      #1;
      chk("R6 drive ATN CLK DATA", {5'd0, bus_data_low, bus_clk_low, bus_atn_low}, 8'(v));
    end
  endtask

  task automatic t_dir;
    pa_bus_out = 3'b000; pa_bus_dir = 3'b000;
    pa_bank_out = 2'b00; pa_bank_dir = 2'b00;
    step(1);
    chk("R7 inputs drive all low", {5'd0, bus_data_low, bus_clk_low, bus_atn_low}, 8'h07);
    chk("R7 inputs bank 0x0000", {6'd0, vid_bank}, 8'h00);
    pa_bus_dir = 3'b101; pa_bank_dir = 2'b01;
    step(1);
    chk("R7 mixed direction drive", {5'd0, bus_data_low, bus_clk_low, bus_atn_low}, 8'h02);
    chk("R7 mixed direction bank", {6'd0, vid_bank}, {6'd0, exp_window(2'b10)});
    pa_bus_dir = 3'b111; pa_bank_dir = 2'b11;
  endtask

  task automatic t_read;
    pa_bus_out = 3'b000; bus_clk_ext = 1'b1; bus_data_ext = 1'b1;
    #1 chk("R8 idle read", pa_rd, 8'hFF);
    bus_clk_ext = 1'b0;
    #1 chk("R8 external CLK low", pa_rd, 8'hBF);
    bus_clk_ext = 1'b1; bus_data_ext = 1'b0;
    #1 chk("R8 external DATA low", pa_rd, 8'h7F);
    bus_data_ext = 1'b1; pa_bus_out = 3'b100;
    #1 chk("R8 local DATA pull", pa_rd, 8'h7F);
    pa_bus_out = 3'b011;
    #1 chk("R8 local CLK pull, ATN no sense", pa_rd, 8'hBF);
    pa_bus_out = 3'b000;
  endtask

  task automatic t_bank;
    pa_bank_dir = 2'b11;
    for (int v = 0; v < 4; v++) begin
      pa_bank_out = 2'(v);
      step(1);
      chk("R9 bank window", {6'd0, vid_bank}, {6'd0, exp_window(2'(v))});
    end
    pa_bank_out = 2'b00;
    #1 chk("R9 bank waits for edge", {6'd0, vid_bank}, {6'd0, exp_window(2'b11)});
    step(1);
    chk("R9 bank 0xC000", {6'd0, vid_bank}, 8'h03);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_irq_timer();
    t_irq_video();
    t_nmi_timer();
    t_nmi_restore();
    t_hold();
    t_drive();
    t_dir();
    t_read();
    t_bank();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule